// File: doc/BRIEF.md
# Store-Load Memory Disambiguation

This block decides, cycle by cycle, whether a load may read memory in a speculative out-of-order core where stores wait in the reorder buffer until they retire. A load arrives with its reorder-buffer index and its computed effective address. The block sees the store entries that are still active in the reorder buffer, with a valid flag, an address-known flag and an address for each. It grants the shared memory port to the load only when no older active store could write the same location.

An older store whose address matches the load's address blocks the load. An older store whose address is not yet known also blocks the load, because its address might turn out to match. Stores that are younger than the load never block it. Age is measured as the distance of an index from the reorder-buffer head, modulo the buffer depth, so the comparison stays correct when the index wraps. Stores write memory only when they commit from the head of the buffer. A committing store takes the single memory port ahead of any load in the same cycle. Because stores write in order, the block does not need to check for write-after-write or write-after-read hazards through memory.

The decision is purely combinational. The grant is valid in the same cycle as the request, and the load's issue logic simply retries a blocked load on a later cycle.

Top module: `mem_disambig`

## Requirements
- R1: A requesting load with no older active store in its way, and no store committing in that cycle, gets `ld_grant`=1 and `ld_conflict`=0.
- R2: An active store that is older than the load, has a known address, and has an address equal to `ld_addr` sets `ld_conflict`=1 and forces `ld_grant`=0.
- R3: An active store that is older than the load and whose address is not yet known (`st_known` bit = 0) sets `ld_conflict`=1 and forces `ld_grant`=0.
- R4: Age is the entry index minus `rob_head`, modulo DEPTH. A store with an age greater than or equal to the load's age never blocks the load, including when the index wraps past DEPTH-1.
- R5: An entry whose `st_valid` bit is 0 never blocks a load, whatever its known flag and address are.
- R6: When `st_commit`=1, the head entry's store writes memory: `mem_wr`=1 and `ld_grant`=0, while `ld_conflict` still reports the address check.
- R7: With `ld_req`=0, both `ld_grant` and `ld_conflict` are 0.
- R8: An older active store with a known address that differs from `ld_addr` does not block the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the embedded checks |
| rst_n | input | 1 | Active-low reset, used only by the embedded checks |
| rob_head | input | IW | Index of the oldest reorder-buffer entry |
| st_valid | input | DEPTH | Bit i is 1 when entry i holds an uncommitted store |
| st_known | input | DEPTH | Bit i is 1 when entry i's store address has been computed |
| st_addr | input | DEPTH*AW | Store address of entry i at bits [i*AW +: AW] |
| st_commit | input | 1 | The store at the head entry commits this cycle |
| ld_req | input | 1 | A load with a computed address requests memory |
| ld_tag | input | IW | Reorder-buffer index of the requesting load |
| ld_addr | input | AW | Effective address of the requesting load |
| ld_grant | output | 1 | The load may use the memory port this cycle |
| ld_conflict | output | 1 | The load is held back by an older store |
| mem_wr | output | 1 | The memory port performs the committing store's write |

## Verification
A wrong age comparison shows at the ports in the same cycle as the bad input. A load gets granted past an older store with a matching or unknown address, or a younger store blocks a load. Such errors tend to appear only for certain head positions, so the stimulus covers every head, load tag, valid mask and known mask of a four-entry configuration. A port-priority error shows as a grant on the cycle that a store commits.

// File: rtl/mem_disambig.sv
module mem_disambig #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IW-1:0]       rob_head,
  input  logic [DEPTH-1:0]    st_valid,
  input  logic [DEPTH-1:0]    st_known,
  input  logic [DEPTH*AW-1:0] st_addr,
  input  logic                st_commit,
  input  logic                ld_req,
  input  logic [IW-1:0]       ld_tag,
  input  logic [AW-1:0]       ld_addr,
  output logic                ld_grant,
  output logic                ld_conflict,
  output logic                mem_wr
);

  logic [IW-1:0]    ld_age;
  logic [DEPTH-1:0] blocker;

  assign ld_age = ld_tag - rob_head;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic [IW-1:0] age;
    logic          older;
    logic          hit;
    assign age   = IW'(i) - rob_head;
    assign older = age < ld_age;
    assign hit   = !st_known[i] || (st_addr[i*AW +: AW] == ld_addr);
    assign blocker[i] = st_valid[i] && older && hit;
  end

  assign ld_conflict = ld_req && (|blocker);
  assign mem_wr      = st_commit;
  assign ld_grant    = ld_req && !(|blocker) && !st_commit;

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_grant && mem_wr)); // R6
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_grant |-> ld_req); // R7
  AST_CONFLICT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_conflict |-> ld_req); // R7
  AST_CONFLICT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_conflict |-> !ld_grant); // R2
  AST_HEAD_NEVER_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && ld_tag == rob_head) |-> !ld_conflict); // R4
  AST_COMMIT_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    st_commit |-> (st_valid[rob_head] && st_known[rob_head])); // R6

endmodule

// File: tb/mem_disambig_tb.sv
module mem_disambig_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] rob_head = 0, ld_tag = 0;
  logic [N-1:0] st_valid = 0, st_known = 0;
  logic [N*AW-1:0] st_addr = 0;
  logic st_commit = 0, ld_req = 0;
  logic [AW-1:0] ld_addr = 0;
  logic ld_grant, ld_conflict, mem_wr;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_disambig #(.DEPTH(N), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rob_head(rob_head), .st_valid(st_valid),
    .st_known(st_known), .st_addr(st_addr), .st_commit(st_commit),
    .ld_req(ld_req), .ld_tag(ld_tag), .ld_addr(ld_addr),
    .ld_grant(ld_grant), .ld_conflict(ld_conflict), .mem_wr(mem_wr));

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b head=%0d tag=%0d v=%b k=%b a=%h la=%0d cm=%0b",
               req, act, exp, rob_head, ld_tag, st_valid, st_known, st_addr, ld_addr, st_commit);
    end
  endtask

  task automatic apply(input int h, input int t, input int v, input int k,
                       input int a, input int la, input bit cm, input bit rq);
    @(negedge clk);
    rob_head = 2'(h); ld_tag = 2'(t); st_valid = 4'(v); st_known = 4'(k);
    st_addr = 8'(a); ld_addr = 2'(la); st_commit = cm; ld_req = rq;
    #1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        #1;
        chk(ld_grant, 1'b0, "R7 reset grant");
        chk(ld_conflict, 1'b0, "R7 reset conflict");
        rst_n = 1;
        // R1: nothing in the way
        apply(0, 3, 0, 0, 0, 1, 0, 1);
        chk(ld_grant, 1'b1, "R1 grant");
        // R2: older matching store (entry 1 addr 2, load addr 2)
        apply(0, 3, 4'b0010, 4'b0010, 8'b00_00_10_00, 2, 0, 1);
        chk(ld_conflict, 1'b1, "R2 conflict");
        chk(ld_grant, 1'b0, "R2 grant");
        // R8: older store with different address
        apply(0, 3, 4'b0010, 4'b0010, 8'b00_00_01_00, 2, 0, 1);
        chk(ld_grant, 1'b1, "R8 grant");
        // R3: older unknown address
        apply(0, 3, 4'b0010, 4'b0000, 0, 2, 0, 1);
        chk(ld_conflict, 1'b1, "R3 conflict");
        // R4: wraparound head=3, load tag=1 (age 2); entry 2 age 3 younger
        apply(3, 1, 4'b0100, 4'b0000, 0, 0, 0, 1);
        chk(ld_grant, 1'b1, "R4 wrap younger");
        // R4: entry 0 age 1 older with wrap
        apply(3, 1, 4'b0001, 4'b0000, 0, 0, 0, 1);
        chk(ld_conflict, 1'b1, "R4 wrap older");
        // R5: invalid unknown entry ignored
        apply(0, 3, 4'b0000, 4'b0000, 0, 0, 0, 1);
        chk(ld_grant, 1'b1, "R5 invalid ignored");
        // R6: commit takes port
        apply(0, 3, 4'b0001, 4'b0001, 8'b00_00_00_01, 2, 1, 1);
        chk(mem_wr, 1'b1, "R6 mem_wr");
        chk(ld_grant, 1'b0, "R6 grant");
        // sweep
        for (int h = 0; h < 4; h++)
          for (int t = 0; t < 4; t++)
            for (int v = 0; v < 16; v++)
              for (int k = 0; k < 16; k++) begin
                int a, la, la_age;
                bit cm, rq, blk, unk;
                a  = (h * 53 + t * 29 + v * 7 + k * 11) & 8'hFF;
                la = (v + k + t) & 3;
                rq = ((v ^ k) & 5) != 5;
                cm = ((v >> h) & 1) && ((k >> h) & 1) && (((v + k) & 3) == 0);
                la_age = (t - h) & 3;
                blk = 0; unk = 0;
                for (int i = 0; i < 4; i++)
                  if (((v >> i) & 1) && (((i - h) & 3) < la_age)) begin
                    if (!((k >> i) & 1)) begin blk = 1; unk = 1; end
                    else if (((a >> (2 * i)) & 3) == la) blk = 1;
                  end
                apply(h, t, v, k, a, la, cm, rq);
                chk(mem_wr, cm, "R6 sweep write");
                chk(ld_conflict, rq && blk,
                    !rq ? "R7 sweep" : unk ? "R3 sweep" : blk ? "R2 sweep" : "R4 sweep");
                chk(ld_grant, rq && !blk && !cm,
                    cm ? "R6 sweep" : !rq ? "R7 sweep" : blk ? "R2 sweep" : "R1 sweep");
              end
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule